// File: doc/BRIEF.md
# Timeslot Zero Ping-Pong Buffer

This block sits at the boundary between an E1 framer and the channel logic. It supplies the timeslot 0 byte for every outgoing frame and takes in the timeslot 0 byte of every incoming frame. The line side marks each frame with a one-cycle strobe. On that strobe the block moves exactly one byte in each direction.

For transmit, the byte comes from one of three sources. The first is a built-in generator that follows the chosen framing format, either double-frame or CRC4 multiframe. The second is a channel-0 FIFO stream. The third is a host-visible RAM area. For receive, the byte goes either to the channel-0 stream or to a matching RAM area.

Each RAM area has two halves of `FRAMES` bytes, one byte per frame of a multiframe. While the line side sends from or fills one half, the host reads or writes the other. The two halves trade places on the last frame of each multiframe. The host side sees a status bit that names the half it owns, and a one-cycle pulse on every swap.

Top module: `ts0_pingpong`

## Requirements
- R1: After reset, `tx_ts0` is 0x00, both host-half bits are 0, and both swap pulses and `h_err` are low.
- R2: In automatic mode (`tx_sel`=0) with `crc4`=0, a strobe on an even frame index yields 0x9B. A strobe on an odd frame index yields 0xDF.
- R3: In automatic mode with `crc4`=1, even frame indices yield 0x9B. Odd frame indices yield `{m,7'h5F}`, where m is 0 for frames 1, 3 and 7, and 1 for frames 5, 9, 11, 13 and 15.
- R4: With `tx_sel`=1 (FIFO), `tx_fifo_rd` is high in the cycle of each strobe. After that edge, `tx_ts0` equals the `tx_fifo_data` value that was present at the strobe.
- R5: With `tx_sel`=2 (RAM), after each strobe `tx_ts0` equals the transmit RAM byte at the current frame index in the half not owned by the host.
- R6: The frame index counts strobes from 0 after reset and wraps after `FRAMES`-1. On the wrapping strobe, a direction in RAM mode toggles its host-half bit and raises its swap pulse for exactly one cycle. A direction not in RAM mode keeps its host-half bit.
- R7: A host write (`h_we`=1, `h_sel_rx`=0) to the transmit half the host owns is stored. The stored byte is then readable at once on `h_rdata`.
- R8: A host write to the transmit half owned by the line, or any write with `h_sel_rx`=1, leaves memory unchanged. It raises `h_err` for one cycle after the edge.
- R9: With `rx_to_ram`=1, each strobe stores `rx_ts0` at the current frame index of the receive half not owned by the host. The host can read that byte after the next swap.
- R10: With `rx_to_ram`=0, `rx_fifo_wr` equals `frame_stb` and `rx_fifo_data` equals `rx_ts0`. With `rx_to_ram`=1, `rx_fifo_wr` stays low.
- R11: Without a strobe, `tx_ts0` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle marker of the timeslot 0 instant of each frame |
| crc4 | input | 1 | Automatic pattern format: 0 double-frame, 1 CRC4 multiframe |
| tx_sel | input | 2 | Transmit source: 0 automatic, 1 FIFO, 2 RAM, 3 automatic |
| rx_to_ram | input | 1 | Receive destination: 0 FIFO stream, 1 RAM |
| tx_fifo_data | input | 8 | Byte offered by the channel-0 transmit stream |
| tx_fifo_rd | output | 1 | Pops one byte from the transmit stream |
| tx_ts0 | output | 8 | Timeslot 0 byte for the current outgoing frame |
| rx_ts0 | input | 8 | Timeslot 0 byte of the incoming frame |
| rx_fifo_wr | output | 1 | Pushes one byte to the receive stream |
| rx_fifo_data | output | 8 | Byte pushed to the receive stream |
| h_sel_rx | input | 1 | Host area select: 0 transmit RAM, 1 receive RAM |
| h_half | input | 1 | Host half select |
| h_addr | input | $clog2(FRAMES) | Host byte index within the half |
| h_we | input | 1 | Host write enable |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational |
| tx_host_half | output | 1 | Transmit half currently owned by the host |
| rx_host_half | output | 1 | Receive half currently owned by the host |
| tx_swap | output | 1 | One-cycle pulse when the transmit halves trade places |
| rx_swap | output | 1 | One-cycle pulse when the receive halves trade places |
| h_err | output | 1 | One-cycle pulse after a rejected host write |

## Verification
A frame counter that drifts shows up in two ways. Automatic CRC4 bytes come out with the multiframe bit in the wrong frame. The swap pulse also fires on a strobe other than the sixteenth, and both can be seen within one multiframe. If the ownership bit is wrong, the line reads the half the host just wrote, so RAM-sourced bytes show stale data on the first multiframe after a swap. Wrong ownership also makes legal host writes raise `h_err` on the very next cycle. Receive bytes that land in the wrong half show up as mismatches when the host reads them back right after the following swap.

// File: rtl/ts0_pingpong.sv
module ts0_pingpong #(
  parameter int FRAMES = 16,
  localparam int AW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic          crc4,
  input  logic [1:0]    tx_sel,
  input  logic          rx_to_ram,
  input  logic [7:0]    tx_fifo_data,
  output logic          tx_fifo_rd,
  output logic [7:0]    tx_ts0,
  input  logic [7:0]    rx_ts0,
  output logic          rx_fifo_wr,
  output logic [7:0]    rx_fifo_data,
  input  logic          h_sel_rx,
  input  logic          h_half,
  input  logic [AW-1:0] h_addr,
  input  logic          h_we,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  output logic          tx_host_half,
  output logic          rx_host_half,
  output logic          tx_swap,
  output logic          rx_swap,
  output logic          h_err
);
  localparam int DEPTH = 2 * FRAMES;
  localparam logic [1:0] SRC_FIFO = 2'd1;
  localparam logic [1:0] SRC_RAM  = 2'd2;
  localparam logic [7:0] ALIGN_WORD = 8'h9B;
  localparam logic [6:0] NONALIGN_LOW = 7'h5F;
  localparam logic [7:0] MF_BITS = 8'hF4;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] idx;
  logic          wrap;
  logic [2:0]    mf_j;
  logic [7:0]    auto_byte;
  logic [7:0]    ram_byte;
  logic          tx_ram, host_ok;

  assign wrap     = (idx == AW'(FRAMES - 1));
  assign mf_j     = 3'(idx >> 1);
  assign tx_ram   = (tx_sel == SRC_RAM);
  assign host_ok  = !h_sel_rx && (h_half == tx_host_half);
  assign ram_byte = tx_mem[{~tx_host_half, idx}];

  always_comb begin
    if (!idx[0])   auto_byte = ALIGN_WORD;
    else if (crc4) auto_byte = {MF_BITS[mf_j], NONALIGN_LOW};
    else           auto_byte = {1'b1, NONALIGN_LOW};
  end

  assign tx_fifo_rd   = frame_stb && (tx_sel == SRC_FIFO);
  assign rx_fifo_wr   = frame_stb && !rx_to_ram;
  assign rx_fifo_data = rx_ts0;
  assign h_rdata      = h_sel_rx ? rx_mem[{h_half, h_addr}] : tx_mem[{h_half, h_addr}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx          <= '0;
      tx_ts0       <= '0;
      tx_host_half <= 1'b0;
      rx_host_half <= 1'b0;
      tx_swap      <= 1'b0;
      rx_swap      <= 1'b0;
      h_err        <= 1'b0;
    end else begin
      tx_swap <= 1'b0;
      rx_swap <= 1'b0;
      h_err   <= h_we && !host_ok;
      if (frame_stb) begin
        idx <= wrap ? '0 : idx + 1'b1;
        case (tx_sel)
          SRC_FIFO: tx_ts0 <= tx_fifo_data;
          SRC_RAM:  tx_ts0 <= ram_byte;
          default:  tx_ts0 <= auto_byte;
        endcase
        if (wrap && tx_ram) begin
          tx_host_half <= ~tx_host_half;
          tx_swap      <= 1'b1;
        end
        if (wrap && rx_to_ram) begin
          rx_host_half <= ~rx_host_half;
          rx_swap      <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (h_we && host_ok) tx_mem[{h_half, h_addr}] <= h_wdata;
    if (frame_stb && rx_to_ram) rx_mem[{~rx_host_half, idx}] <= rx_ts0;
  end

  assert_fifo_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_rd |=> tx_ts0 == $past(tx_fifo_data));
  assert_swap_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_swap |-> tx_host_half != $past(tx_host_half));
  assert_rx_swap_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_swap |-> rx_host_half != $past(rx_host_half));
  assert_swap_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_swap || rx_swap) |-> $past(frame_stb));
  assert_err_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    h_err |-> $past(h_we));
  assert_no_rx_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_to_ram |-> !rx_fifo_wr);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(tx_ts0));
endmodule

// File: tb/sim_ts0_pingpong.sv
module sim_ts0_pingpong;
  localparam int FR = 16;
  logic clk = 0, rst_n = 0, frame_stb = 0, crc4 = 0, rx_to_ram = 0;
  logic [1:0] tx_sel = 0;
  logic [7:0] tx_fifo_data = 0, rx_ts0 = 0, h_wdata = 0;
  logic h_sel_rx = 0, h_half = 0, h_we = 0;
  logic [3:0] h_addr = 0;
  logic tx_fifo_rd, rx_fifo_wr, tx_host_half, rx_host_half, tx_swap, rx_swap, h_err;
  logic [7:0] tx_ts0, rx_fifo_data, h_rdata;
  int n_chk = 0, n_bad = 0, fc = 0;
  logic s_rd, s_wr;
  logic [7:0] s_wd;
  bit done = 0;

  always #2.5 clk = ~clk;

  ts0_pingpong #(.FRAMES(FR)) u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] rxb);
    @(negedge clk);
    frame_stb = 1; rx_ts0 = rxb;
    #1; s_rd = tx_fifo_rd; s_wr = rx_fifo_wr; s_wd = rx_fifo_data;
    @(negedge clk);
    frame_stb = 0;
    fc = (fc + 1) % FR;
  endtask

  function automatic logic [7:0] exp_auto(int k, bit c);
    if (k % 2 == 0) return 8'h9B;
    if (!c) return 8'hDF;
    return (k == 5 || k >= 9) ? 8'hDF : 8'h5F;
  endfunction

  task automatic hwrite(input bit rx, input bit half, input int a, input logic [7:0] d, input bit exp_err);
    @(negedge clk);
    h_sel_rx = rx; h_half = half; h_addr = 4'(a); h_wdata = d; h_we = 1;
    @(negedge clk);
    h_we = 0;
    chk(exp_err ? "R8 err pulse" : "R7 no err", {7'd0, h_err}, {7'd0, exp_err});
    @(negedge clk);
    chk("R8 err one cycle", {7'd0, h_err}, 8'd0);
  endtask

  task automatic hread(input bit rx, input bit half, input int a, output logic [7:0] d);
    h_sel_rx = rx; h_half = half; h_addr = 4'(a);
    #1 d = h_rdata;
  endtask

  task t_reset;
    chk("R1 tx_ts0", tx_ts0, 8'h00);
    chk("R1 halves", {6'd0, tx_host_half, rx_host_half}, 8'd0);
    chk("R1 pulses", {5'd0, tx_swap, rx_swap, h_err}, 8'd0);
  endtask

  task automatic t_auto(input bit c);
    crc4 = c; tx_sel = 0; rx_to_ram = 0;
    for (int i = 0; i < FR; i++) begin
      int k = fc;
      strobe(8'h10 + 8'(i));
      chk(c ? "R3 crc4 byte" : "R2 double-frame byte", tx_ts0, exp_auto(k, c));
      chk("R10 rx push", {7'd0, s_wr}, 8'd1);
      chk("R10 rx data", s_wd, 8'h10 + 8'(i));
      chk("R6 no swap pulse", {6'd0, tx_swap, rx_swap}, 8'd0);
    end
    chk("R6 halves kept", {6'd0, tx_host_half, rx_host_half}, 8'd0);
    repeat (3) @(negedge clk);
    chk("R11 hold", tx_ts0, exp_auto(FR - 1, c));
  endtask

  task t_fifo;
    tx_sel = 1;
    for (int i = 0; i < FR; i++) begin
      tx_fifo_data = 8'h60 ^ 8'(i * 7);
      strobe(8'h00);
      chk("R4 pop strobe", {7'd0, s_rd}, 8'd1);
      chk("R4 fifo byte", tx_ts0, 8'h60 ^ 8'(i * 7));
    end
    tx_sel = 0;
    @(negedge clk);
    chk("R4 no pop idle", {7'd0, tx_fifo_rd}, 8'd0);
  endtask

  task t_host;
    logic [7:0] b0, b1;
    for (int i = 0; i < FR; i++) hwrite(0, 0, i, 8'h40 + 8'(i), 0);
    for (int i = 0; i < FR; i++) begin
      hread(0, 0, i, b0);
      chk("R7 readback", b0, 8'h40 + 8'(i));
    end
    hread(0, 1, 3, b0);
    hwrite(0, 1, 3, 8'hEE, 1);
    hread(0, 1, 3, b1);
    chk("R8 line half untouched", b1, b0);
    hread(1, 0, 4, b0);
    hwrite(1, 0, 4, 8'hEE, 1);
    hread(1, 0, 4, b1);
    chk("R8 rx area untouched", b1, b0);
  endtask

  task t_ram;
    logic [7:0] b;
    tx_sel = 2; rx_to_ram = 1;
    for (int i = 0; i < FR; i++) begin
      strobe(8'hA0 + 8'(i));
      chk("R10 no rx push", {7'd0, s_wr}, 8'd0);
      chk("R6 swap only at wrap", {6'd0, tx_swap, rx_swap}, (i == FR - 1) ? 8'd3 : 8'd0);
    end
    chk("R6 halves toggled", {6'd0, tx_host_half, rx_host_half}, 8'd3);
    @(negedge clk);
    chk("R6 pulse one cycle", {6'd0, tx_swap, rx_swap}, 8'd0);
    for (int i = 0; i < FR; i++) begin
      hread(1, 1, i, b);
      chk("R9 rx stored", b, 8'hA0 + 8'(i));
    end
    hwrite(0, 0, 0, 8'h77, 1);
    for (int i = 0; i < FR; i++) begin
      strobe(8'hC0 + 8'(i));
      chk("R5 ram byte", tx_ts0, 8'h40 + 8'(i));
    end
    chk("R6 halves back", {6'd0, tx_host_half, rx_host_half}, 8'd0);
    for (int i = 0; i < FR; i++) begin
      hread(1, 0, i, b);
      chk("R9 rx second half", b, 8'hC0 + 8'(i));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_auto(0);
    t_auto(1);
    t_fifo();
    t_host();
    t_ram();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule